// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block is a byte-level I2C bus master controlled by a host through a command port and a status word. The host writes a 3-bit operation code. The engine then performs that single operation on the bus: a start condition, a stop condition, a byte write, or a byte read that ends with either an acknowledge or a not-acknowledge from the master. It reports completion, the level of the acknowledge slot, and any loss of arbitration in a 4-bit status word. The last code written can be read back at any time.

Both bus lines are driven open-drain. Each output is a pull-down enable: 1 pulls the line low and 0 releases it. The bus levels are read back through a two-flop synchronizer. Each bit period is split into four quarters. A quarter lasts `quarter_div + 1` system clocks, taken from a 16-bit divider value. The engine reads SCL back and waits while another device holds it low. After every operation other than a stop, the engine leaves SCL pulled low, so the host has time to decide on the next operation.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, the status word is 0, `last_cmd` is 0, and both pull-down outputs are 0, so the bus is released.
- R2: Operation codes are 0 = NOP, 1 = START, 2 = STOP, 3 = WRITE, 4 = READ with ACK, and 5 = READ with NACK. An accepted write stores the code in `last_cmd`. NOP, 6 and 7 complete on the write edge itself, with done = 1 and busy = 0.
- R3: The status bits are done (bit 0), no-acknowledge (bit 1), lost-arbitration (bit 2) and busy (bit 3). An accepted command clears done, no-acknowledge and lost-arbitration on its write edge. For codes 1 to 5 it sets busy. Busy stays high until done is set.
- R4: With divider value P (P ≥ 2), done rises exactly 4·(P+1) clocks after the write edge for START and STOP. For the three byte operations it rises exactly 36·(P+1) clocks after the write edge, provided no device holds SCL low.
- R5: START makes SDA fall while SCL is high, and then leaves both lines pulled low. STOP makes SDA rise while SCL is high, and then leaves both lines released.
- R6: WRITE sends `tx_byte` MSB first, one bit per rising SCL edge. SDA changes only while SCL is low, so no start or stop condition appears. SCL is left pulled low afterwards.
- R7: At the end of every byte operation, no-acknowledge equals the SDA level in the ninth bit slot (1 = NACK). This holds when a slave drives that slot (WRITE) and when the master drives it (READ with ACK gives 0, READ with NACK gives 1).
- R8: A READ places the eight bits seen on SDA, MSB first, into `rx_byte`.
- R9: During WRITE, if the engine releases SDA for a 1 but samples it low while SCL is high, it sets lost-arbitration. It releases both lines for the rest of the byte and still completes at the R4 time. It leaves the bus released.
- R10: A command written while busy is ignored: `last_cmd` does not change and the running operation completes at its R4 time.
- R11: After releasing SCL for a bit, the engine does not take its mid-bit sample or continue until the synchronized SCL reads high. While an external device holds SCL low, the operation does not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | One-cycle strobe that writes `cmd_code` |
| cmd_code | input | 3 | Operation code (see R2) |
| tx_byte | input | 8 | Byte to send, latched on an accepted write |
| quarter_div | input | 16 | Clocks per quarter bit, minus one |
| last_cmd | output | 3 | Last accepted operation code |
| status | output | 4 | {busy, lost_arb, no_ack, done} |
| rx_byte | output | 8 | Last byte received by READ |
| scl_in | input | 1 | Wired SCL level |
| sda_in | input | 1 | Wired SDA level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The arbitration comparison and the mid-bit data sample fall on the same quarter edge. On that edge a loss must also release SCL and SDA, while the quarter count keeps running toward completion. The bench provokes this with a competing device that drives 0xF0 while the engine sends 0xFF. It judges the result by the lost-arbitration bit, the released lines, and a completion time that is unchanged from a clean byte. A second coincidence is a command strobe that lands in the middle of a running byte. It is judged by an unchanged `last_cmd` and an unchanged completion cycle.

// File: rtl/i2cm_pkg.sv
// Package: shared operation codes for the command-driven I2C master.
// Assumes a 3-bit command field; codes 6 and 7 are treated as no-ops.
package i2cm_pkg;
    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_START     = 3'd1,
        OP_STOP      = 3'd2,
        OP_WRITE     = 3'd3,
        OP_READ_ACK  = 3'd4,
        OP_READ_NACK = 3'd5
    } op_e;
endpackage

// File: rtl/i2cm_sync.sv
// Module: multi-stage synchronizer for the wired bus levels.
// Assumes STAGES >= 2; resets to all ones (idle bus is high).
module i2cm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the sampled levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2cm_qtick.sv
// Module: quarter-bit timebase. Emits one tick every LIMIT+1 clocks while run
// is high; clr restarts the count. Assumes limit is held steady while running.
module i2cm_qtick #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    // Count clocks within a quarter; restart on clear, tick or idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (clr || tick || !run)  cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0) |=> !tick); // R4
endmodule

// File: rtl/i2c_cmd_master.sv
// Module: command-driven I2C byte master. Executes one operation per accepted
// command, sequencing each bit in four quarters (drive SDA, release SCL,
// sample, pull SCL). Assumes quarter_div >= 2 so synchronized levels settle
// before sampling. Outputs are pull-down enables for open-drain lines.
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PRESC_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [2:0]         cmd_code,
    input  logic [DATA_W-1:0]  tx_byte,
    input  logic [PRESC_W-1:0] quarter_div,
    output logic [2:0]         last_cmd,
    output logic [3:0]         status,
    output logic [DATA_W-1:0]  rx_byte,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_pull,
    output logic               sda_pull
);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);

    logic [1:0]        bus_s;
    logic              scl_s, sda_s;
    logic [2:0]        cmd_q;
    logic              busy_q, done_q, nack_q, lost_q;
    logic [1:0]        phase_q;
    logic [BIT_W-1:0]  slot_q;
    logic [DATA_W-1:0] txsh_q, rx_q;
    logic              scl_q, sda_q;
    logic              tick, accept, op_valid, is_byte, is_write, in_data;
    logic              stall, adv, bit_drive, arb_hit, finish;

    i2cm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    i2cm_qtick #(.W(PRESC_W)) u_qtick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_q),
        .clr   (accept),
        .limit (quarter_div),
        .tick  (tick)
    );

    // Decode the accepted command and the current bit position.
    assign accept    = cmd_wr && !busy_q;
    assign op_valid  = (cmd_code >= 3'd1) && (cmd_code <= 3'd5);
    assign is_write  = (cmd_q == OP_WRITE);
    assign is_byte   = is_write || (cmd_q == OP_READ_ACK) || (cmd_q == OP_READ_NACK);
    assign in_data   = (slot_q != ACK_SLOT);
    assign bit_drive = in_data ? (is_write && !txsh_q[DATA_W-1]) : (cmd_q == OP_READ_ACK);
    assign arb_hit   = is_write && in_data && txsh_q[DATA_W-1] && !sda_s;
    // Hold the mid-bit quarter while SCL still reads low (readback).
    assign stall     = (phase_q == 2'd2) && !scl_s && !lost_q;
    assign adv       = busy_q && tick && !stall;
    assign finish    = adv && (phase_q == 2'd3) && (!is_byte || !in_data);

    // Command acceptance, sequencing, sampling and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            nack_q  <= 1'b0;
            lost_q  <= 1'b0;
            phase_q <= '0;
            slot_q  <= '0;
            txsh_q  <= '0;
            rx_q    <= '0;
        end else if (accept) begin
            cmd_q   <= cmd_code;
            busy_q  <= op_valid;
            done_q  <= !op_valid;
            nack_q  <= 1'b0;
            lost_q  <= 1'b0;
            phase_q <= '0;
            slot_q  <= '0;
            txsh_q  <= tx_byte;
        end else if (adv) begin
            phase_q <= phase_q + 2'd1;
            if (is_byte && phase_q == 2'd2) begin
                if (!in_data)     nack_q <= sda_s;
                else if (arb_hit) lost_q <= 1'b1;
                if (in_data && !is_write && !lost_q)
                    rx_q <= {rx_q[DATA_W-2:0], sda_s};
            end
            if (is_byte && phase_q == 2'd3 && in_data) begin
                slot_q <= slot_q + 1'b1;
                txsh_q <= txsh_q << 1;
            end
            if (finish) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    // Drive the open-drain pull enables for each quarter of each operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b0;
            sda_q <= 1'b0;
        end else if (adv) begin
            case (cmd_q)
                OP_START: begin
                    case (phase_q)
                        2'd0: sda_q <= 1'b0;
                        2'd1: scl_q <= 1'b0;
                        2'd2: sda_q <= 1'b1;
                        default: scl_q <= 1'b1;
                    endcase
                end
                OP_STOP: begin
                    case (phase_q)
                        2'd0: sda_q <= 1'b1;
                        2'd1: scl_q <= 1'b0;
                        2'd2: sda_q <= 1'b0;
                        default: ;
                    endcase
                end
                default: begin
                    if (is_byte) begin
                        if (phase_q == 2'd2 && arb_hit) begin
                            scl_q <= 1'b0;
                            sda_q <= 1'b0;
                        end else if (!lost_q) begin
                            case (phase_q)
                                2'd0: sda_q <= bit_drive;
                                2'd1: scl_q <= 1'b0;
                                2'd3: scl_q <= 1'b1;
                                default: ;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    assign last_cmd = cmd_q;
    assign status   = {busy_q, lost_q, nack_q, done_q};
    assign rx_byte  = rx_q;
    assign scl_pull = scl_q;
    assign sda_pull = sda_q;

    AST_NEW_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (!done_q && !nack_q && !lost_q)); // R3
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && is_byte && !lost_q && !$stable(sda_q))
        |-> ($past(scl_q) && scl_q)); // R6
    AST_PARK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && cmd_q != OP_STOP && !lost_q) |-> (scl_q && done_q)); // R6
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && cmd_q == OP_STOP) |-> (!scl_q && !sda_q)); // R5
    AST_LOST_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q |-> (!scl_q && !sda_q)); // R9
    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cmd_wr) |=> $stable(cmd_q)); // R10
endmodule

// File: tb/i2c_cmd_master_tb.sv
// Bench: sweeps every byte value through WRITE and READ, varies the quarter
// divider, and models a slave, a competing master and a clock-holding device.
module i2c_cmd_master_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr;
    logic [2:0]  cmd_code;
    logic [7:0]  tx_byte;
    logic [15:0] quarter_div;
    logic [2:0]  last_cmd;
    logic [3:0]  status;
    logic [7:0]  rx_byte;
    logic        scl_pull, sda_pull;
    logic        scl_line, sda_line;
    logic        hold_scl, slv_pull, slv_ack;
    logic [7:0]  slv_byte;
    int          slv_mode, fall_cnt, base, slv_idx;
    int          cap_n, start_cnt, stop_cnt, P;
    logic [8:0]  cap;
    bit          armed, finished;
    int          nchk, nfail;

    always #5 clk = ~clk;

    assign scl_line = !(scl_pull || hold_scl);
    assign sda_line = !(sda_pull || slv_pull);

    i2c_cmd_master u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .tx_byte(tx_byte), .quarter_div(quarter_div), .last_cmd(last_cmd),
        .status(status), .rx_byte(rx_byte), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    // Slave / competitor model: mode 1 acks a write, mode 2 drives a byte.
    always_comb begin
        slv_idx = fall_cnt - base;
        case (slv_mode)
            1:       slv_pull = (slv_idx == 8) && slv_ack;
            2:       slv_pull = (slv_idx >= 0 && slv_idx < 8) ? !slv_byte[7 - slv_idx] : 1'b0;
            default: slv_pull = 1'b0;
        endcase
    end

    always @(negedge scl_line) fall_cnt++;
    always @(posedge scl_line) begin cap = {cap[7:0], sda_line}; cap_n++; end
    always @(negedge sda_line) if (armed && scl_line === 1'b1) start_cnt++;
    always @(posedge sda_line) if (armed && scl_line === 1'b1) stop_cnt++;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c);
        @(negedge clk); cmd_code = c; cmd_wr = 1'b1;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    // Done must rise exactly q quarters after the write edge.
    task automatic finish_at(input int q, input int elapsed, input string rq);
        repeat (q * (P + 1) - 1 - elapsed) @(negedge clk);
        chk(status[0] == 1'b0, {rq, " done early"}, status, 0);
        @(negedge clk);
        chk(status[0] == 1'b1 && status[3] == 1'b0, {rq, " done on time"}, status, 1);
    endtask

    task automatic do_cmd(input logic [2:0] c, input int q, input string rq);
        issue(c);
        chk(status[3] == 1'b1 && status[0] == 1'b0, "R3 busy after write", status, 8);
        finish_at(q, 0, rq);
    endtask

    task automatic set_div(input int v);
        quarter_div = 16'(v); P = v;
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit ack);
        int s0, e0;
        s0 = start_cnt; e0 = stop_cnt; cap_n = 0;
        slv_mode = 1; slv_ack = ack; base = fall_cnt; tx_byte = b;
        do_cmd(3'd3, 36, "R4 write");
        chk(cap[8:1] == b && cap_n == 9, "R6 msb-first data", cap[8:1], b);
        chk(status[1] == !ack, "R7 slave ack slot", status[1], !ack);
        chk(scl_pull == 1'b1, "R6 scl parked low", scl_pull, 1);
        chk(start_cnt == s0 && stop_cnt == e0, "R6 no sda edge while scl high", start_cnt + stop_cnt, s0 + e0);
        slv_mode = 0;
    endtask

    task automatic rd_byte(input logic [7:0] b, input bit ack);
        cap_n = 0; slv_mode = 2; slv_byte = b; base = fall_cnt;
        do_cmd(ack ? 3'd4 : 3'd5, 36, "R4 read");
        chk(rx_byte == b, "R8 read data", rx_byte, b);
        chk(status[1] == !ack && cap[0] == !ack, "R7 master ack slot", status[1], !ack);
        slv_mode = 0;
    endtask

    task automatic start_bus();
        int s0;
        s0 = start_cnt;
        do_cmd(3'd1, 4, "R4 start");
        chk(start_cnt == s0 + 1, "R5 start edge", start_cnt, s0 + 1);
        chk(scl_pull && sda_pull, "R5 lines held after start", {scl_pull, sda_pull}, 3);
    endtask

    task automatic stop_bus();
        int e0;
        e0 = stop_cnt;
        do_cmd(3'd2, 4, "R4 stop");
        chk(stop_cnt == e0 + 1, "R5 stop edge", stop_cnt, e0 + 1);
        chk(!scl_pull && !sda_pull, "R5 lines released after stop", {scl_pull, sda_pull}, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog act=0 exp=1");
        summary();
    end

    initial begin
        nchk = 0; nfail = 0; finished = 0; armed = 0;
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_code = '0; tx_byte = '0;
        hold_scl = 1'b0; slv_mode = 0; slv_ack = 0; slv_byte = '0;
        fall_cnt = 0; base = 0; cap_n = 0; cap = '0; start_cnt = 0; stop_cnt = 0;
        set_div(2);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;
        chk(status == 4'd0 && last_cmd == 3'd0, "R1 reset status", {last_cmd, status}, 0);
        chk(!scl_pull && !sda_pull, "R1 bus released", {scl_pull, sda_pull}, 0);

        // R2: NOP and unused codes finish on the write edge.
        issue(3'd0);
        chk(status == 4'b0001 && last_cmd == 3'd0, "R2 nop done", status, 1);
        issue(3'd7);
        chk(status == 4'b0001 && last_cmd == 3'd7, "R2 code 7 as nop", {last_cmd, status}, 8'h71);

        // Full write sweep at P=2, ack alternating with the byte's LSB.
        start_bus();
        chk(last_cmd == 3'd1, "R2 last_cmd start", last_cmd, 1);
        for (int b = 0; b < 256; b++) wr_byte(8'(b), !b[0]);

        // R10: a command strobe while busy is ignored.
        slv_mode = 1; slv_ack = 1'b1; base = fall_cnt; tx_byte = 8'hA5; cap_n = 0;
        issue(3'd3);
        repeat (20) @(negedge clk);
        cmd_code = 3'd2; cmd_wr = 1'b1;
        @(negedge clk); cmd_wr = 1'b0;
        chk(last_cmd == 3'd3, "R10 last_cmd unchanged", last_cmd, 3);
        finish_at(36, 21, "R10 completion");
        chk(cap[8:1] == 8'hA5, "R10 byte intact", cap[8:1], 8'hA5);
        slv_mode = 0;
        stop_bus();

        // Full read sweep at P=3, alternating ACK and NACK.
        set_div(3);
        start_bus();
        for (int b = 0; b < 256; b++) rd_byte(8'(b), b[1]);
        stop_bus();

        // R4: timing over several divider values.
        for (int d = 4; d <= 6; d++) begin
            set_div(d);
            start_bus();
            wr_byte(8'h3C, 1'b1);
            stop_bus();
        end

        // R11: an external device holds SCL low.
        set_div(2);
        start_bus();
        hold_scl = 1'b1; slv_mode = 1; slv_ack = 1'b1; base = fall_cnt;
        tx_byte = 8'h81; cap_n = 0;
        issue(3'd3);
        repeat (36 * 3) @(negedge clk);
        chk(status[0] == 1'b0, "R11 no completion while held", status[0], 0);
        chk(cap_n == 0 && scl_pull == 1'b0, "R11 waits with scl released", cap_n, 0);
        hold_scl = 1'b0;
        for (int i = 0; i < 3000 && status[0] == 1'b0; i++) @(negedge clk);
        chk(status[0] == 1'b1, "R11 completes after release", status[0], 1);
        chk(cap[8:1] == 8'h81 && status[1] == 1'b0, "R11 byte after stretch", cap[8:1], 8'h81);
        slv_mode = 0;
        stop_bus();

        // R9: competitor drives 0xF0 while the engine sends 0xFF.
        start_bus();
        slv_mode = 2; slv_byte = 8'hF0; base = fall_cnt; tx_byte = 8'hFF;
        do_cmd(3'd3, 36, "R9 completion time");
        chk(status[2] == 1'b1, "R9 lost flag", status[2], 1);
        chk(!scl_pull && !sda_pull, "R9 bus released", {scl_pull, sda_pull}, 0);
        issue(3'd0);
        chk(status == 4'b0001, "R3 new command clears lost", status, 1);

        summary();
    end
endmodule